// File: doc/BRIEF.md
# UART Control and Status Register Bank

This block is the software-visible register file of a serial port. A host reaches it over a simple 16-bit register bus with a byte address, a write strobe, a read strobe, write data and registered read data. It holds the baud divisor halves, global, line and modem control, a scratch word, the line and modem status words, the interrupt enable word, the transmit holding byte and the receive buffer byte. The shifter, baud generator and receive path live elsewhere. They reach the bank through a few plain inputs: live line status bits, a clear-to-send level and change pulse, and a received-byte strobe with its data.

Each register has its own write rule. Control, divisor and scratch words take whatever is written. The interrupt enable word can only be changed through two aliases: one ORs bits in and the other clears the bits written as one. Some status bits are sticky and are cleared by writing one. Other status bits and the receive buffer ignore writes. A write to the transmit holding register hands the byte to the transmitter with a one-cycle strobe. If the transmit-empty enable is set, the same write also raises a one-cycle interrupt event.

Top module: `uart_regbank`

## Requirements
- R1: After reset, every register reads back 0, except the low divisor, which reads 0x0001, and line status, which reads 0x0060. bus_err, tx_strobe, tx_irq, tx_data and bus_rdata are all 0.
- R2: The registers sit at a 4-byte stride. The byte offsets are: 0x00 low divisor, 0x04 high divisor, 0x08 global control, 0x0C line control, 0x10 modem control, 0x14 line status, 0x18 modem status, 0x1C scratch, 0x20 enable-set alias, 0x24 enable-clear alias, 0x28 transmit holding, 0x2C receive buffer. Read data appears on bus_rdata in the cycle after bus_rd is sampled. bus_rdata is 0 in the cycle after any edge where no read was sampled.
- R3: The low divisor, high divisor, global control, line control, modem control and scratch registers store all 16 written bits and return them on read.
- R4: A write to the enable-set alias ORs the write data into the interrupt enable word.
- R5: A write to the enable-clear alias clears every enable bit written as 1 and leaves the others alone. A read of either alias returns the enable word.
- R6: A read of line status returns the stored word ORed with line_live. The same read folds line_live into the stored word, so the folded bits stay set after line_live drops.
- R7: In line status, only bits 7 (transmit done), 4 (break), 3 (framing error), 2 (parity error) and 1 (overrun) are cleared by writing 1 (mask 0x009E). Writing to any other line status bit has no effect.
- R8: In modem status, bit 0 is a sticky flag set by a cts_change pulse and cleared by writing 1 to bit 0. Bit 4 reads the live cts_level. All other bits read 0 and ignore writes. When a set and a clear land on the same cycle, the set wins.
- R9: The receive buffer loads rx_data when rx_valid is high. A read returns that byte zero-extended. Writes to it change nothing.
- R10: A write to transmit holding stores the low byte of the write data, which reads back zero-extended. In the next cycle, tx_strobe is high for exactly one cycle and tx_data shows the byte.
- R11: tx_irq is high together with that tx_strobe only if interrupt enable bit 1 (transmit-empty enable) was set when the write was sampled.
- R12: An access to an offset that is not a multiple of 4, or that lies beyond 0x2C, changes no register. Such a read returns 0, and bus_err is high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (6) | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Registered read data |
| bus_err | output | 1 | One-cycle flag for a bad access |
| line_live | input | DATA_W (16) | Live line status bits merged on read |
| cts_change | input | 1 | Pulse that sets the sticky clear-to-send change flag |
| cts_level | input | 1 | Live clear-to-send level |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_strobe | output | 1 | One-cycle pulse after a transmit holding write |
| tx_data | output | 8 | Byte held for the transmitter |
| tx_irq | output | 1 | One-cycle transmit interrupt event |

## Verification
Some behaviour is checked on every cycle by the assertions. These cover the bad-access flag and its zeroed read data, the quiet read bus on cycles with no read, and the timing of the transmit strobe and its data byte. They also check that an interrupt event never appears without a strobe or without the enable, how the two enable aliases act, and that the receive buffer holds steady when the host writes to it. Other behaviour can only be shown by the bench's scenarios, because it needs a history of several accesses: the reset contents, plain read-back, sticky line status bits kept after the live input drops, write-one-to-clear acting on only the masked bits, the set-over-clear priority in modem status, and the fact that rejected writes leave their neighbours unchanged.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

  localparam int NUM_REGS = 12;
  localparam int BYTE_W   = 8;

  // register slots, one per 4-byte word
  localparam int IDX_DIV_LO   = 0;
  localparam int IDX_DIV_HI   = 1;
  localparam int IDX_GLB_CTRL = 2;
  localparam int IDX_LINE_CTL = 3;
  localparam int IDX_MODEM_CT = 4;
  localparam int IDX_LINE_ST  = 5;
  localparam int IDX_MODEM_ST = 6;
  localparam int IDX_SCRATCH  = 7;
  localparam int IDX_IEN_SET  = 8;
  localparam int IDX_IEN_CLR  = 9;
  localparam int IDX_TX_HOLD  = 10;
  localparam int IDX_RX_BUF   = 11;

  // line status sticky bit positions
  localparam int LS_TX_DONE = 7;
  localparam int LS_BREAK   = 4;
  localparam int LS_FRAME   = 3;
  localparam int LS_PARITY  = 2;
  localparam int LS_OVERRUN = 1;

  // modem status bit positions
  localparam int MS_CTS_CHG  = 0;
  localparam int MS_CTS_LIVE = 4;

  // interrupt enable bit positions
  localparam int IEN_TX_EMPTY = 1;

  function automatic logic is_plain(input int idx);
    return (idx == IDX_DIV_LO)   || (idx == IDX_DIV_HI)   ||
           (idx == IDX_GLB_CTRL) || (idx == IDX_LINE_CTL) ||
           (idx == IDX_MODEM_CT) || (idx == IDX_SCRATCH);
  endfunction

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rd,
  input  logic                wr,
  output logic [NUM_REGS-1:0] rd_hit,
  output logic [NUM_REGS-1:0] wr_hit,
  output logic                bad
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  logic [IDX_W-1:0] idx;
  logic             mapped;

  always_comb begin
    idx    = addr[ADDR_W-1:2];
    mapped = (addr[1:0] == 2'b00) && (idx <= LAST_IDX);
    bad    = (rd || wr) && !mapped;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    always_comb begin
      rd_hit[i] = rd && mapped && (idx == IDX_W'(i));
      wr_hit[i] = wr && mapped && (idx == IDX_W'(i));
    end
  end

endmodule

// File: rtl/uart_rb_inten.sv
module uart_rb_inten #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ien_q
);

  logic [DATA_W-1:0] ien_d;
  logic              ien_en;

  always_comb begin
    ien_en = set_we || clr_we;
    ien_d  = ien_q;
    if (set_we) ien_d = ien_q | wdata;
    if (clr_we) ien_d = ien_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_en) ien_q <= ien_d;
  end

endmodule

// File: rtl/uart_rb_status.sv
module uart_rb_status
  import uart_rb_pkg::*;
#(
  parameter int              DATA_W  = 16,
  parameter logic [DATA_W-1:0] LSR_RST = 16'h0060
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ls_rd,
  input  logic              ls_wr,
  input  logic              ms_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] line_live,
  input  logic              cts_change,
  input  logic              cts_level,
  output logic [DATA_W-1:0] ls_view,
  output logic [DATA_W-1:0] ms_view
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam logic [DATA_W-1:0] LS_W1C =
    (ONE << LS_TX_DONE) | (ONE << LS_BREAK) | (ONE << LS_FRAME) |
    (ONE << LS_PARITY)  | (ONE << LS_OVERRUN);

  logic [DATA_W-1:0] ls_q, ls_d;
  logic              ls_en;
  logic              cts_chg_q, cts_chg_d;
  logic              cts_en;

  always_comb begin
    ls_en = ls_rd || ls_wr;
    ls_d  = ls_q;
    if (ls_rd) ls_d = ls_d | line_live;
    if (ls_wr) ls_d = ls_d & ~(wdata & LS_W1C);
  end

  always_comb begin
    cts_en    = cts_change || ms_wr;
    cts_chg_d = cts_chg_q;
    if (ms_wr && wdata[MS_CTS_CHG]) cts_chg_d = 1'b0;
    if (cts_change)                 cts_chg_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ls_q <= LSR_RST;
    else if (ls_en) ls_q <= ls_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cts_chg_q <= 1'b0;
    else if (cts_en) cts_chg_q <= cts_chg_d;
  end

  always_comb begin
    ls_view = ls_q | line_live;
    ms_view = '0;
    ms_view[MS_CTS_CHG]  = cts_chg_q;
    ms_view[MS_CTS_LIVE] = cts_level;
  end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int                ADDR_W     = 6,
  parameter int                DATA_W     = 16,
  parameter logic [DATA_W-1:0] DIV_LO_RST = 16'h0001,
  parameter logic [DATA_W-1:0] LSR_RST    = 16'h0060
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic [DATA_W-1:0] line_live,
  input  logic              cts_change,
  input  logic              cts_level,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              tx_strobe,
  output logic [7:0]        tx_data,
  output logic              tx_irq
);

  localparam int PAD_W = DATA_W - BYTE_W;

  logic [NUM_REGS-1:0] rd_hit, wr_hit;
  logic                bad;
  logic [DATA_W-1:0]   ier_q;
  logic [DATA_W-1:0]   ls_view, ms_view;
  logic [DATA_W-1:0]   plain_q [NUM_REGS];
  logic [DATA_W-1:0]   src     [NUM_REGS];
  logic [BYTE_W-1:0]   thr_q, rbr_q;
  logic [DATA_W-1:0]   rd_val;
  logic                strobe_d, irq_d;

  uart_rb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .rd     (bus_rd),
    .wr     (bus_wr),
    .rd_hit (rd_hit),
    .wr_hit (wr_hit),
    .bad    (bad)
  );

  uart_rb_inten #(.DATA_W(DATA_W)) u_ien (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (wr_hit[IDX_IEN_SET]),
    .clr_we (wr_hit[IDX_IEN_CLR]),
    .wdata  (bus_wdata),
    .ien_q  (ier_q)
  );

  uart_rb_status #(.DATA_W(DATA_W), .LSR_RST(LSR_RST)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .ls_rd      (rd_hit[IDX_LINE_ST]),
    .ls_wr      (wr_hit[IDX_LINE_ST]),
    .ms_wr      (wr_hit[IDX_MODEM_ST]),
    .wdata      (bus_wdata),
    .line_live  (line_live),
    .cts_change (cts_change),
    .cts_level  (cts_level),
    .ls_view    (ls_view),
    .ms_view    (ms_view)
  );

  // plain read/write words
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_plain
    if (is_plain(i)) begin : g_reg
      localparam logic [DATA_W-1:0] RST_V = (i == IDX_DIV_LO) ? DIV_LO_RST : '0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         plain_q[i] <= RST_V;
        else if (wr_hit[i]) plain_q[i] <= bus_wdata;
      end
    end else begin : g_none
      assign plain_q[i] = '0;
    end
  end

  // transmit holding and receive buffer bytes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   thr_q <= '0;
    else if (wr_hit[IDX_TX_HOLD]) thr_q <= bus_wdata[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rbr_q <= '0;
    else if (rx_valid) rbr_q <= rx_data;
  end

  // read source selection
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) src[i] = plain_q[i];
    src[IDX_LINE_ST]  = ls_view;
    src[IDX_MODEM_ST] = ms_view;
    src[IDX_IEN_SET]  = ier_q;
    src[IDX_IEN_CLR]  = ier_q;
    src[IDX_TX_HOLD]  = {{PAD_W{1'b0}}, thr_q};
    src[IDX_RX_BUF]   = {{PAD_W{1'b0}}, rbr_q};
    rd_val = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_hit[i]) rd_val = rd_val | src[i];
    end
  end

  always_comb begin
    strobe_d = wr_hit[IDX_TX_HOLD];
    irq_d    = wr_hit[IDX_TX_HOLD] && ier_q[IEN_TX_EMPTY];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      tx_strobe <= 1'b0;
      tx_irq    <= 1'b0;
    end else begin
      bus_rdata <= rd_val;
      bus_err   <= bad;
      tx_strobe <= strobe_d;
      tx_irq    <= irq_d;
    end
  end

  assign tx_data = thr_q;

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk
  import uart_rb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic              rx_valid,
  input logic              tx_strobe,
  input logic [7:0]        tx_data,
  input logic              tx_irq,
  input logic [DATA_W-1:0] ier_q,
  input logic [7:0]        rbr_q
);

  localparam logic [ADDR_W-1:0] OFF_SET = ADDR_W'(IDX_IEN_SET * 4);
  localparam logic [ADDR_W-1:0] OFF_CLR = ADDR_W'(IDX_IEN_CLR * 4);
  localparam logic [ADDR_W-1:0] OFF_TX  = ADDR_W'(IDX_TX_HOLD * 4);
  localparam logic [ADDR_W-1:0] OFF_RX  = ADDR_W'(IDX_RX_BUF * 4);

  // R12
  misaligned_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) && (bus_addr[1:0] != 2'b00) |=> bus_err && (bus_rdata == '0));

  // R2
  idle_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);

  // R10
  tx_strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (bus_addr == OFF_TX) |=> tx_strobe && (tx_data == $past(bus_wdata[7:0])));

  // R10
  tx_strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> $past(bus_wr) && ($past(bus_addr) == OFF_TX));

  // R11
  irq_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_strobe);

  // R11
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> $past(ier_q[IEN_TX_EMPTY]));

  // R4
  set_alias_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (bus_addr == OFF_SET) |=> (ier_q & $past(bus_wdata)) == $past(bus_wdata));

  // R5
  clr_alias_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (bus_addr == OFF_CLR) |=> (ier_q & $past(bus_wdata)) == '0);

  // R9
  rx_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (bus_addr == OFF_RX) && !rx_valid |=> $stable(rbr_q));

endmodule

bind uart_regbank uart_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .rx_valid  (rx_valid),
  .tx_strobe (tx_strobe),
  .tx_data   (tx_data),
  .tx_irq    (tx_irq),
  .ier_q     (ier_q),
  .rbr_q     (rbr_q)
);

// File: tb/uart_regbank_test.sv
module uart_regbank_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  b_addr;
  logic        b_wr, b_rd;
  logic [15:0] b_wdata;
  logic [15:0] b_rdata;
  logic        b_err;
  logic [15:0] live;
  logic        cts_chg, cts_lvl;
  logic        rxv;
  logic [7:0]  rxd;
  logic        txs;
  logic [7:0]  txd;
  logic        txi;

  int vectors = 0;
  int misses  = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [15:0] m_reg [12];
  logic        m_cts;
  logic [15:0] e_rdata;
  logic        e_err, e_str, e_irq;
  logic [7:0]  e_txd;

  always #10 clk = ~clk;

  uart_regbank uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (b_addr),
    .bus_wr     (b_wr),
    .bus_rd     (b_rd),
    .bus_wdata  (b_wdata),
    .bus_rdata  (b_rdata),
    .bus_err    (b_err),
    .line_live  (live),
    .cts_change (cts_chg),
    .cts_level  (cts_lvl),
    .rx_valid   (rxv),
    .rx_data    (rxd),
    .tx_strobe  (txs),
    .tx_data    (txd),
    .tx_irq     (txi)
  );

  task automatic model_reset();
    for (int i = 0; i < 12; i++) m_reg[i] = 16'h0000;
    m_reg[0] = 16'h0001;
    m_reg[5] = 16'h0060;
    m_cts = 1'b0;
    e_rdata = '0; e_err = 0; e_str = 0; e_irq = 0; e_txd = '0;
  endtask

  task automatic model_step();
    int  idx;
    bit  ok;
    logic [15:0] ier_old;
    idx = int'(b_addr) / 4;
    ok  = (b_addr[1:0] == 2'b00) && (idx < 12);
    ier_old = m_reg[8];
    e_rdata = '0;
    e_err = (b_rd || b_wr) && !ok;
    e_str = 0;
    e_irq = 0;
    if (b_rd && ok) begin
      case (idx)
        5:       e_rdata = m_reg[5] | live;
        6:       e_rdata = {11'd0, cts_lvl, 3'd0, m_cts};
        9:       e_rdata = m_reg[8];
        default: e_rdata = m_reg[idx];
      endcase
      if (idx == 5) m_reg[5] = m_reg[5] | live;
    end
    if (b_wr && ok) begin
      case (idx)
        0, 1, 2, 3, 4, 7: m_reg[idx] = b_wdata;
        5:  m_reg[5] = m_reg[5] & ~(b_wdata & 16'h009E);
        6:  if (b_wdata[0]) m_cts = 1'b0;
        8:  m_reg[8] = m_reg[8] | b_wdata;
        9:  m_reg[8] = m_reg[8] & ~b_wdata;
        10: begin
          m_reg[10] = {8'h00, b_wdata[7:0]};
          e_str = 1;
          e_irq = ier_old[1];
        end
        default: ;
      endcase
    end
    if (cts_chg) m_cts = 1'b1;
    if (rxv) m_reg[11] = {8'h00, rxd};
    e_txd = m_reg[10][7:0];
  endtask

  task automatic compare();
    vectors++;
    if (b_rdata !== e_rdata || b_err !== e_err || txs !== e_str ||
        txd !== e_txd || txi !== e_irq) begin
      misses++;
      $display("FAIL %s: rdata/err/strobe/data/irq actual %h/%b/%b/%h/%b expected %h/%b/%b/%h/%b",
               cur_req, b_rdata, b_err, txs, txd, txi,
               e_rdata, e_err, e_str, e_txd, e_irq);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    b_rd = 0; b_wr = 0; cts_chg = 0; rxv = 0;
  endtask

  task automatic rd(input logic [5:0] a);
    b_addr = a; b_rd = 1; b_wr = 0;
    step();
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    b_addr = a; b_wdata = d; b_wr = 1; b_rd = 0;
    step();
  endtask

  task automatic idle();
    step();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: run did not finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rst_n = 0; b_addr = '0; b_wr = 0; b_rd = 0; b_wdata = '0;
    live = '0; cts_chg = 0; cts_lvl = 0; rxv = 0; rxd = '0;
    model_reset();
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1;

    // R1: reset contents of every slot
    cur_req = "R1";
    for (int i = 0; i < 12; i++) rd(6'(i * 4));

    // R3 and R2: plain words and offsets
    cur_req = "R3";
    wr(6'h00, 16'hBEEF); wr(6'h04, 16'h1234); wr(6'h08, 16'h00F0);
    wr(6'h0C, 16'h8001); wr(6'h10, 16'h5A5A); wr(6'h1C, 16'hFFFF);
    for (int i = 0; i < 8; i++) rd(6'(i * 4));
    cur_req = "R2";
    idle(); idle();
    rd(6'h1C); idle();

    // R4 / R5: enable aliases
    cur_req = "R4";
    wr(6'h20, 16'h0005); wr(6'h20, 16'h0012); rd(6'h20);
    cur_req = "R5";
    rd(6'h24); wr(6'h24, 16'h0014); rd(6'h20); rd(6'h24);

    // R6: live merge and stickiness
    cur_req = "R6";
    live = 16'h0010; rd(6'h14);
    live = 16'h0000; rd(6'h14);
    live = 16'h0100; idle(); live = 16'h0000; rd(6'h14);

    // R7: write-one-to-clear mask
    cur_req = "R7";
    wr(6'h14, 16'hFFFF); rd(6'h14);
    live = 16'h009E; rd(6'h14); live = 16'h0000;
    wr(6'h14, 16'h0004); rd(6'h14);
    wr(6'h14, 16'h0060); rd(6'h14);

    // R8: modem status
    cur_req = "R8";
    cts_chg = 1; idle(); rd(6'h18);
    cts_lvl = 1; rd(6'h18);
    wr(6'h18, 16'hFFFE); rd(6'h18);
    wr(6'h18, 16'h0001); rd(6'h18);
    b_addr = 6'h18; b_wdata = 16'h0001; b_wr = 1; cts_chg = 1; step();
    rd(6'h18); cts_lvl = 0; rd(6'h18);

    // R9: receive buffer
    cur_req = "R9";
    rxd = 8'hA5; rxv = 1; idle(); rd(6'h2C);
    wr(6'h2C, 16'h1234); rd(6'h2C);
    rxd = 8'h3C; rxv = 1; idle(); rd(6'h2C);

    // R10 / R11: transmit path
    cur_req = "R10";
    wr(6'h24, 16'hFFFF);
    wr(6'h28, 16'h12C3); idle(); rd(6'h28);
    cur_req = "R11";
    wr(6'h20, 16'h0002); wr(6'h28, 16'h0077); idle();
    wr(6'h28, 16'hFF01); wr(6'h28, 16'h0002); idle();
    wr(6'h24, 16'h0002); wr(6'h28, 16'h0099); idle();

    // R12: bad accesses
    cur_req = "R12";
    rd(6'h30); rd(6'h3C); rd(6'h02); idle();
    wr(6'h31, 16'hDEAD); wr(6'h06, 16'hDEAD); wr(6'h3C, 16'hDEAD);
    rd(6'h04); rd(6'h2C); rd(6'h1C);
    wr(6'h29, 16'h0055); idle(); rd(6'h28);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule